// File: doc/BRIEF.md
# CAN Frame Error Detector

This block follows a standard-format CAN data or remote frame (11-bit identifier) one sampled bit at a time and reports protocol violations. A bit-timing front end delivers each bus sample as a one-cycle strobe. With the strobe come the sampled bus level, the level this node is driving, a flag saying whether this node is transmitting, and a listen-only flag. The detector tracks the frame fields itself: it reads the DLC to size the data field, removes stuff bits, runs the 15-bit CRC and checks the fixed-format delimiters.

Each sample arrives as a valid-only beat. The block has no ready output and never applies back-pressure, because bus bits cannot be held back, so every strobe is consumed in the cycle it is seen. All outputs are registered. Each one is a single-cycle pulse in the clock cycle after the strobe that caused it. That lets the error-frame logic downstream start its frame at the next bit time. After any error the detector ignores the bus until it has seen 11 consecutive recessive samples, and then waits for a new start-of-frame.

Top module: `can_err_detect`

## Requirements
- R1: Inside the stuffed region, which runs from start-of-frame through the last CRC bit and includes a stuff bit that follows that last bit, a sample equal to the five before it raises `err_stuff`. A sample of the opposite level in that position is dropped and is neither counted as a field bit nor fed to the CRC.
- R2: From the CRC delimiter onward no destuffing is done, so a run of seven or more recessive bits in the trailing fields raises no flag.
- R3: While `tx_active` is high and `listen_only` is low, a sample that differs from `tx_lvl` raises `err_bit`. This applies to stuff bits as well.
- R4: In the identifier and RTR bits (not stuff bits), driving recessive (1) and sampling dominant (0) pulses `arb_lost` and raises no `err_bit`. The same case in the ACK slot raises nothing.
- R5: A dominant (0) sample in the CRC delimiter, the ACK delimiter or any of the 7 end-of-frame bits raises `err_form`.
- R6: The CRC is x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 with a zero start value, taken MSB-first over start-of-frame through the end of the data field. A received CRC field that does not match raises `err_crc` on the ACK delimiter sample.
- R7: The data field holds min(DLC,8) bytes for a data frame (RTR bit 0) and no bytes for a remote frame (RTR bit 1), whatever the DLC.
- R8: Any flag from R1, R3, R5 or R6 pulses `err_frame_req` in the same cycle (outside listen-only mode). The detector then ignores the bus until it has seen 11 consecutive recessive samples.
- R9: With `listen_only` high, `err_stuff`, `err_form` and `err_crc` still pulse, but `err_frame_req` and `err_bit` stay low.
- R10: Every output is high for exactly one cycle, namely the cycle after the strobe that caused it. Several error flags may be high on the same sample.
- R11: A frame that completes with no error pulses `frame_ok` on its seventh end-of-frame sample.
- R12: A recessive IDE bit (extended format) drops the frame without any flag, and the detector waits for bus idle as in R8.
- R13: During and right after reset (`rst_n` low) every output is low and the detector waits for start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per bit time |
| rx_lvl | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| tx_lvl | input | 1 | Level this node drives in the sampled bit |
| tx_active | input | 1 | This node is transmitting the current frame |
| listen_only | input | 1 | Listen-only mode, no error frames requested |
| err_stuff | output | 1 | Stuff error pulse |
| err_bit | output | 1 | Bit error pulse |
| err_form | output | 1 | Form error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_frame_req | output | 1 | Request an error frame from the next bit |
| arb_lost | output | 1 | Arbitration lost pulse |
| frame_ok | output | 1 | Frame completed without error |

## Verification
If the field counter slips, the fault shows up within the same frame. The delimiter check falls on a data bit, so `err_form` fires on a dominant bit, or `frame_ok` appears on the wrong sample. A run counter that is off by one flags a stuff error one bit early or late, or misses it, right at the sixth equal bit. A corrupted CRC register or a wrong DLC decode stays hidden until the ACK delimiter or the shifted end-of-frame, so every frame is checked bit by bit up to its final sample.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_RTR,
    ST_IDE,
    ST_R0,
    ST_DLC,
    ST_DATA,
    ST_CRC,
    ST_CRC_DEL,
    ST_ACK,
    ST_ACK_DEL,
    ST_EOF,
    ST_WAIT
  } fld_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfd_destuff.sv
module cfd_destuff #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic rx,
  input  logic start,
  input  logic clear,
  output logic due,
  output logic stuff_err
);
  localparam int RW = $clog2(RUN + 1);

  logic          en_q;
  logic          last_q;
  logic [RW-1:0] run_q;

  assign due       = en_q && (run_q == RW'(RUN));
  assign stuff_err = smp_vld && due && (rx == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      last_q <= 1'b1;
      run_q  <= '0;
    end else if (smp_vld) begin
      if (start) begin
        en_q   <= 1'b1;
        last_q <= rx;
        run_q  <= RW'(1);
      end else if (clear) begin
        en_q  <= 1'b0;
        run_q <= '0;
      end else if (en_q) begin
        if (due || (rx != last_q)) begin
          run_q  <= RW'(1);
          last_q <= rx;
        end else begin
          run_q <= run_q + RW'(1);
        end
      end
    end
  end

  // R1
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && due && !stuff_err && !clear && !start) |=> (run_q == RW'(1)));

endmodule

// File: rtl/cfd_crc.sv
module cfd_crc #(
  parameter int              W    = 15,
  parameter logic [W-1:0]    POLY = 15'h4599
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         feed,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic fb;
  assign fb = din ^ crc_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clear) begin
      crc_q <= '0;
    end else if (feed) begin
      crc_q <= {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end
  end

  // R6
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == '0));

endmodule

// File: rtl/cfd_field_seq.sv
module cfd_field_seq
  import cfd_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int CRC_W     = 15,
  parameter int EOF_LEN   = 7,
  parameter int IDLE_RUN  = 11,
  parameter int MAX_BYTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic rx,
  input  logic tx,
  input  logic tx_active,
  input  logic listen_only,
  input  logic due,
  input  logic stuff_err,
  input  logic crc_nz,
  output logic start,
  output logic dstf_clear,
  output logic crc_feed,
  output logic e_bit,
  output logic e_form,
  output logic e_crc,
  output logic arb_lost,
  output logic frame_ok
);
  localparam int MAXB    = MAX_BYTES * 8;
  localparam int CNT_MAX = imax(imax(MAXB, IDLE_RUN), imax(imax(CRC_W, ID_W), EOF_LEN));
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int DW      = $clog2(MAXB + 1);

  fld_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    dlc_q;
  logic          rtr_q;
  logic [DW-1:0] nbits_q;

  logic [3:0]    dlc_nx;
  logic [DW-1:0] nbits_nx;
  logic          in_frame, consume, is_arb, mism, ack_pass, any_err;

  assign dlc_nx = {dlc_q[2:0], rx};

  always_comb begin
    if (rtr_q) begin
      nbits_nx = '0;
    end else if (dlc_nx >= 4'(MAX_BYTES)) begin
      nbits_nx = DW'(MAXB);
    end else begin
      nbits_nx = DW'({dlc_nx, 3'b000});
    end
  end

  assign in_frame = (st_q != ST_IDLE) && (st_q != ST_WAIT);
  assign consume  = smp_vld && in_frame && !due;
  assign is_arb   = (st_q == ST_ID) || (st_q == ST_RTR);

  assign mism     = smp_vld && in_frame && tx_active && !listen_only && (rx != tx);
  assign arb_lost = mism && tx && !rx && is_arb && !due;
  assign ack_pass = mism && tx && !rx && (st_q == ST_ACK);
  assign e_bit    = mism && !arb_lost && !ack_pass;

  assign e_form = consume && !rx &&
                  ((st_q == ST_CRC_DEL) || (st_q == ST_ACK_DEL) || (st_q == ST_EOF));
  assign e_crc  = consume && (st_q == ST_ACK_DEL) && crc_nz;

  assign any_err = e_bit || e_form || e_crc || stuff_err;

  assign start      = smp_vld && (st_q == ST_IDLE) && !rx;
  assign dstf_clear = any_err ||
                      (consume && ((st_q == ST_CRC_DEL) || ((st_q == ST_IDE) && rx)));
  assign crc_feed   = consume && !any_err &&
                      ((st_q == ST_ID) || (st_q == ST_RTR) || (st_q == ST_IDE) ||
                       (st_q == ST_R0) || (st_q == ST_DLC) || (st_q == ST_DATA) ||
                       (st_q == ST_CRC));
  assign frame_ok   = consume && !any_err && (st_q == ST_EOF) &&
                      (cnt_q == CW'(EOF_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      dlc_q   <= '0;
      rtr_q   <= 1'b0;
      nbits_q <= '0;
    end else if (smp_vld) begin
      if (any_err) begin
        st_q  <= ST_WAIT;
        cnt_q <= '0;
      end else if (consume || !in_frame) begin
        case (st_q)
          ST_IDLE: begin
            if (!rx) begin
              st_q  <= ST_ID;
              cnt_q <= '0;
            end
          end
          ST_ID: begin
            if (cnt_q == CW'(ID_W - 1)) begin
              st_q  <= ST_RTR;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_RTR: begin
            rtr_q <= rx;
            st_q  <= ST_IDE;
          end
          ST_IDE: begin
            st_q  <= rx ? ST_WAIT : ST_R0;
            cnt_q <= '0;
          end
          ST_R0: begin
            st_q  <= ST_DLC;
            cnt_q <= '0;
          end
          ST_DLC: begin
            dlc_q <= dlc_nx;
            if (cnt_q == CW'(3)) begin
              nbits_q <= nbits_nx;
              st_q    <= (nbits_nx == '0) ? ST_CRC : ST_DATA;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_DATA: begin
            if (cnt_q == CW'(nbits_q - DW'(1))) begin
              st_q  <= ST_CRC;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_CRC: begin
            if (cnt_q == CW'(CRC_W - 1)) begin
              st_q  <= ST_CRC_DEL;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_CRC_DEL: st_q <= ST_ACK;
          ST_ACK:     st_q <= ST_ACK_DEL;
          ST_ACK_DEL: begin
            st_q  <= ST_EOF;
            cnt_q <= '0;
          end
          ST_EOF: begin
            if (cnt_q == CW'(EOF_LEN - 1)) begin
              st_q  <= ST_IDLE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_WAIT: begin
            if (!rx) begin
              cnt_q <= '0;
            end else if (cnt_q == CW'(IDLE_RUN - 1)) begin
              st_q  <= ST_IDLE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          default: st_q <= ST_WAIT;
        endcase
      end
    end
  end

  // R8
  err_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && any_err) |=> (st_q == ST_WAIT));

  // R11
  sof_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (st_q == ST_IDLE) && !rx) |=> (st_q == ST_ID));

  // R12
  ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && (st_q == ST_IDE) && rx) |=> (st_q == ST_WAIT));

endmodule

// File: rtl/can_err_detect.sv
module can_err_detect
  import cfd_pkg::*;
#(
  parameter int             ID_W      = 11,
  parameter int             CRC_W     = 15,
  parameter logic [14:0]    CRC_POLY  = 15'h4599,
  parameter int             STUFF_RUN = 5,
  parameter int             EOF_LEN   = 7,
  parameter int             IDLE_RUN  = 11,
  parameter int             MAX_BYTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic rx_lvl,
  input  logic tx_lvl,
  input  logic tx_active,
  input  logic listen_only,
  output logic err_stuff,
  output logic err_bit,
  output logic err_form,
  output logic err_crc,
  output logic err_frame_req,
  output logic arb_lost,
  output logic frame_ok
);
  logic             due, stf_err, start, dclr, crc_feed;
  logic             e_bit, e_form, e_crc, arb_c, ok_c, crc_nz;
  logic [CRC_W-1:0] crc_q;

  assign crc_nz = |crc_q;

  cfd_destuff #(.RUN(STUFF_RUN)) u_destuff (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .rx(rx_lvl),
    .start(start), .clear(dclr), .due(due), .stuff_err(stf_err)
  );

  cfd_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(start), .feed(crc_feed),
    .din(rx_lvl), .crc_q(crc_q)
  );

  cfd_field_seq #(
    .ID_W(ID_W), .CRC_W(CRC_W), .EOF_LEN(EOF_LEN),
    .IDLE_RUN(IDLE_RUN), .MAX_BYTES(MAX_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .rx(rx_lvl), .tx(tx_lvl),
    .tx_active(tx_active), .listen_only(listen_only), .due(due),
    .stuff_err(stf_err), .crc_nz(crc_nz), .start(start), .dstf_clear(dclr),
    .crc_feed(crc_feed), .e_bit(e_bit), .e_form(e_form), .e_crc(e_crc),
    .arb_lost(arb_c), .frame_ok(ok_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_stuff     <= 1'b0;
      err_bit       <= 1'b0;
      err_form      <= 1'b0;
      err_crc       <= 1'b0;
      err_frame_req <= 1'b0;
      arb_lost      <= 1'b0;
      frame_ok      <= 1'b0;
    end else begin
      err_stuff     <= stf_err;
      err_bit       <= e_bit;
      err_form      <= e_form;
      err_crc       <= e_crc;
      err_frame_req <= (stf_err || e_bit || e_form || e_crc) && !listen_only;
      arb_lost      <= arb_c;
      frame_ok      <= ok_c;
    end
  end

  // R8
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame_req |-> (err_stuff || err_bit || err_form || err_crc));

  // R9
  req_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame_req |-> !$past(listen_only));

  // R3
  bit_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_bit |-> ($past(tx_active) && !$past(listen_only)));

  // R10
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stuff || err_bit || err_form || err_crc) |=>
      !(err_stuff || err_bit || err_form || err_crc));

  // R6
  crc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |-> $past(crc_nz));

  // R11
  ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> !(err_stuff || err_bit || err_form || err_crc));

endmodule

// File: tb/can_err_detect_tb.sv
`timescale 1ns/1ps
module can_err_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic smp_vld = 1'b0, rx_i = 1'b1, tx_i = 1'b1, txa_i = 1'b0, lo_i = 1'b0;
  logic err_stuff, err_bit, err_form, err_crc, err_frame_req, arb_lost, frame_ok;

  can_err_detect dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .rx_lvl(rx_i), .tx_lvl(tx_i),
    .tx_active(txa_i), .listen_only(lo_i), .err_stuff(err_stuff), .err_bit(err_bit),
    .err_form(err_form), .err_crc(err_crc), .err_frame_req(err_frame_req),
    .arb_lost(arb_lost), .frame_ok(frame_ok)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit sbits [0:299];
  bit isstuff [0:299];
  int slen, p_crcdel, p_ack, p_ackdel, p_eof0, p_last;
  logic [7:0] dat [0:7];

  function automatic logic [6:0] outs();
    return {err_stuff, err_bit, err_form, err_crc, err_frame_req, arb_lost, frame_ok};
  endfunction

  task automatic check(input string tag, input int idx, input logic [6:0] got,
                       input logic [6:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s bit %0d: got %b expected %b", tag, idx, got, exp);
    end
  endtask

  task automatic build(input logic [10:0] id, input bit rtr, input bit ide,
                       input logic [3:0] dlc, input logic [14:0] cx);
    bit u [0:127];
    int n, nb, run;
    bit last, fb;
    logic [14:0] c;
    n = 0;
    u[n] = 1'b0; n++;
    for (int k = 10; k >= 0; k--) begin u[n] = id[k]; n++; end
    u[n] = rtr; n++;
    u[n] = ide; n++;
    u[n] = 1'b0; n++;
    for (int k = 3; k >= 0; k--) begin u[n] = dlc[k]; n++; end
    nb = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
    for (int b = 0; b < nb; b++)
      for (int k = 7; k >= 0; k--) begin u[n] = dat[b][k]; n++; end
    c = '0;
    for (int k = 0; k < n; k++) begin
      fb = u[k] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    c = c ^ cx;
    for (int k = 14; k >= 0; k--) begin u[n] = c[k]; n++; end
    slen = 0; run = 0; last = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k == 0 || u[k] != last) run = 1; else run++;
      last = u[k];
      sbits[slen] = u[k]; isstuff[slen] = 1'b0; slen++;
      if (run == 5) begin
        last = ~last;
        sbits[slen] = last; isstuff[slen] = 1'b1; slen++;
        run = 1;
      end
    end
    p_crcdel = slen; sbits[slen] = 1'b1; isstuff[slen] = 1'b0; slen++;
    p_ack    = slen; sbits[slen] = 1'b0; isstuff[slen] = 1'b0; slen++;
    p_ackdel = slen; sbits[slen] = 1'b1; isstuff[slen] = 1'b0; slen++;
    p_eof0   = slen;
    for (int k = 0; k < 7; k++) begin sbits[slen] = 1'b1; isstuff[slen] = 1'b0; slen++; end
    p_last = slen - 1;
  endtask

  task automatic send(input bit r, input bit t, input bit ta, input bit l,
                      output logic [6:0] got);
    @(negedge clk);
    smp_vld = 1'b1; rx_i = r; tx_i = t; txa_i = ta; lo_i = l;
    @(negedge clk);
    smp_vld = 1'b0;
    got = outs();
  endtask

  // flags vector order: {stuff, bit, form, crc}
  task automatic run_frame(input int flip_idx, input int err_idx, input logic [3:0] ef,
                           input int arb_idx, input bit lo, input bit txa,
                           input bit txinv, input bit exp_ok, input string tag);
    logic [6:0] got, exp;
    bit r, t, ta;
    for (int i = 0; i < slen; i++) begin
      r  = sbits[i] ^ (i == flip_idx);
      t  = txinv ? ~sbits[i] : sbits[i];
      if (txa && i == p_ack) t = 1'b1;
      if (i == arb_idx) t = 1'b1;
      ta = txa && (arb_idx < 0 || i <= arb_idx);
      send(r, t, ta, lo, got);
      exp = {((i == err_idx) ? ef : 4'b0000),
             (i == err_idx) && (ef != 4'b0000) && !lo,
             (i == arb_idx),
             exp_ok && (err_idx < 0) && (i == p_last)};
      check(tag, i, got, exp);
      if (i == err_idx) begin
        @(negedge clk);
        check("R10", i, outs(), 7'b0);
        break;
      end
    end
    for (int k = 0; k < 12; k++) begin
      send(1'b1, 1'b1, 1'b0, lo, got);
      check("R8", -1, got, 7'b0);
    end
  endtask

  function automatic int pick_stuff(input int which);
    int cnt = 0;
    for (int i = 1; i < p_crcdel; i++)
      if (isstuff[i]) begin
        if (cnt == which) return i;
        cnt++;
      end
    return -1;
  endfunction

  function automatic int count_stuff();
    int cnt = 0;
    for (int i = 1; i < p_crcdel; i++) if (isstuff[i]) cnt++;
    return cnt;
  endfunction

  function automatic int pick_zero(input int which);
    int cnt = 0, lastz = -1;
    for (int i = 1; i < p_crcdel; i++)
      if (!isstuff[i] && !sbits[i]) begin
        lastz = i;
        if (cnt == which) return i;
        cnt++;
      end
    return lastz;
  endfunction

  task automatic rand_data();
    for (int b = 0; b < 8; b++) dat[b] = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed, kind, idx, ns;
    logic [10:0] id;
    logic [3:0] dlc;
    bit rtr, lo;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13", -1, outs(), 7'b0);
    rst_n = 1'b1;

    // R11 plain data frame
    dat[0] = 8'hA5; dat[1] = 8'h3C;
    build(11'h123, 1'b0, 1'b0, 4'd2, 15'h0);
    run_frame(-1, -1, 4'b0, -1, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
    // R7 remote frame with DLC 8: no data field
    build(11'h2F0, 1'b1, 1'b0, 4'd8, 15'h0);
    run_frame(-1, -1, 4'b0, -1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    // R7 DLC above 8 carries 8 bytes
    rand_data();
    build(11'h055, 1'b0, 1'b0, 4'd13, 15'h0);
    run_frame(-1, -1, 4'b0, -1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    // R6 corrupted CRC field
    build(11'h4A1, 1'b0, 1'b0, 4'd1, 15'h0010);
    run_frame(-1, p_ackdel, 4'b0001, -1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    // R1 sixth equal bit right after SOF (identifier zero: stuff bit at 5)
    build(11'h000, 1'b0, 1'b0, 4'd0, 15'h0);
    run_frame(5, 5, 4'b1000, -1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R9 same error in listen-only: flag without request
    run_frame(5, 5, 4'b1000, -1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    // R5 dominant in delimiters and last EOF bit
    build(11'h3A7, 1'b0, 1'b0, 4'd1, 15'h0);
    run_frame(p_crcdel, p_crcdel, 4'b0010, -1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    run_frame(p_ackdel, p_ackdel, 4'b0010, -1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    run_frame(p_last, p_last, 4'b0010, -1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R4 transmitter sees dominant ACK: no bit error
    run_frame(-1, -1, 4'b0, -1, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    // R4 lost arbitration on first identifier bit
    build(11'h155, 1'b0, 1'b0, 4'd1, 15'h0);
    run_frame(-1, -1, 4'b0, 1, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    // R3 bit error: dominant driven, recessive read
    idx = pick_zero(3);
    run_frame(idx, idx, 4'b0100, -1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    // R9 listen-only with mismatching drive: no bit error
    run_frame(-1, -1, 4'b0, -1, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
    // R12 extended IDE drops frame silently, next frame still received
    build(11'h0F3, 1'b0, 1'b1, 4'd2, 15'h0);
    run_frame(-1, -1, 4'b0, -1, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
    build(11'h0F3, 1'b0, 1'b0, 4'd2, 15'h0);
    run_frame(-1, -1, 4'b0, -1, 1'b0, 1'b0, 1'b0, 1'b1, "R12");

    for (int f = 0; f < 150; f++) begin
      rand_data();
      id   = 11'($urandom);
      dlc  = 4'($urandom);
      rtr  = ($urandom % 5) == 0;
      lo   = ($urandom % 4) == 0;
      kind = $urandom % 6;
      case (kind)
        0: begin
          build(id, rtr, 1'b0, dlc, 15'h0);
          run_frame(-1, -1, 4'b0, -1, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        end
        1: begin
          build(id, rtr, 1'b0, dlc, 15'(1 + $urandom % 32767));
          run_frame(-1, p_ackdel, 4'b0001, -1, lo, 1'b0, 1'b0, 1'b0, "R6");
        end
        2: begin
          build(id, rtr, 1'b0, dlc, 15'h0);
          ns = count_stuff();
          if (ns == 0) begin
            run_frame(-1, -1, 4'b0, -1, lo, 1'b0, 1'b0, 1'b1, "R1");
          end else begin
            idx = pick_stuff($urandom % ns);
            run_frame(idx, idx, 4'b1000, -1, lo, 1'b0, 1'b0, 1'b0, "R1");
          end
        end
        3: begin
          build(id, rtr, 1'b0, dlc, 15'h0);
          case ($urandom % 3)
            0: idx = p_crcdel;
            1: idx = p_ackdel;
            default: idx = p_eof0 + ($urandom % 7);
          endcase
          run_frame(idx, idx, 4'b0010, -1, lo, 1'b0, 1'b0, 1'b0, "R5");
        end
        4: begin
          build(id, rtr, 1'b0, dlc, 15'h0);
          idx = pick_zero($urandom % 40);
          run_frame(idx, idx, 4'b0100, -1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        end
        default: begin
          build(id, rtr, 1'b0, dlc, 15'h0);
          run_frame(-1, -1, 4'b0, -1, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
        end
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule